// File: doc/BRIEF.md
# Power-Up Mode Selection Sequencer

This block decides, after the device reset is released, whether the converter core is run by software through its control registers or by mode pins. Coming out of reset it holds the core in a low-power state and counts rising edges of the audio frame clock. The number of frames it waits depends on the speed mode. If a control-enable write arrives while it waits, the block commits to software mode. If the wait runs out first, it commits to hardware mode and lets the core run from its pins. A control-enable write that arrives after hardware mode has begun still moves the block into software mode.

In software mode the block keeps the core powered down while the power-down bit is set, so registers can be loaded safely. Clearing the bit starts a power-up ramp that lasts a fixed number of system clock cycles, about 50 µs by default. The ready flag is raised when the ramp ends. Setting the bit again drops straight back to the held state. The frame clock is asynchronous to the system clock: it is synchronized inside the block and only its rising edges are counted.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `mode_sel` is 2'b00 (pending), `low_power` is 1 and `pwrup_done` is 0.
- R2: While pending, the block counts rising edges of `frame_clk` after synchronizing it. The wait spans W frames, where `speed_code` 2'b00 gives W = BASE_FRAMES, 2'b01 gives 2*BASE_FRAMES, and 2'b10 or 2'b11 gives 4*BASE_FRAMES. The code is read live while the block waits.
- R3: If no control-enable write has arrived, hardware mode is entered on the clock that processes the W-th rising frame edge, and not earlier. Hardware mode means `mode_sel` = 2'b10, `low_power` = 0 and `pwrup_done` = 1.
- R4: A one-cycle `cpen_wr` pulse while pending selects software mode (`mode_sel` = 2'b01) on the next clock. The pulse takes priority over a window expiry in the same cycle.
- R5: A `cpen_wr` pulse while in hardware mode switches to software mode on the next clock, with `low_power` = 1 and `pwrup_done` = 0.
- R6: Once software mode is selected it is kept until reset. Further `cpen_wr` pulses and further frame edges change neither `mode_sel` nor the power outputs.
- R7: In software mode, while `pdn_bit` is 1, `low_power` is 1 and `pwrup_done` is 0.
- R8: In software mode with `pdn_bit` at 0, `low_power` falls on the first clock that samples the 0. `pwrup_done` then rises exactly RAMP_CYCLES clocks later, provided `pdn_bit` stays 0.
- R9: If `pdn_bit` returns to 1 during the ramp or after `pwrup_done`, the next clock restores `low_power` = 1 and `pwrup_done` = 0. A later clear runs the full ramp again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device reset, active low, asynchronous assert |
| frame_clk | input | 1 | Audio frame clock, asynchronous to `clk` |
| speed_code | input | 2 | Speed mode: 00 single, 01 double, 10/11 quad |
| cpen_wr | input | 1 | One-cycle strobe: control-enable bit written |
| pdn_bit | input | 1 | Current value of the power-down register bit |
| mode_sel | output | 2 | 00 pending, 01 software, 10 hardware |
| low_power | output | 1 | Core held in low-power / filter hold |
| pwrup_done | output | 1 | Core running (hardware mode, or ramp finished) |

## Verification
Every speed code, including the alias 11, is tried with a frame count one short of its window and then with the frame that completes it. This separates the correct window length from lengths that are off by one or taken from the wrong code. Random runs choose a speed code and place the enable write either inside the window or after hardware mode has started. These runs tell an early software take-over apart from a late switch out of hardware mode, and they show that extra frame edges are ignored once a mode is chosen. Ramp tests clear the power-down bit and sample the ready flag on the cycle before and the cycle of its expected rise. They then set the bit mid-ramp and check that the held state returns and that the full ramp length is needed again.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    MODE_PEND = 2'b00,
    MODE_SW   = 2'b01,
    MODE_HW   = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_HW   = 3'd1,
    ST_HOLD = 3'd2,
    ST_RAMP = 3'd3,
    ST_RUN  = 3'd4
  } state_e;

  // Frames in the decision window: base scaled by 1, 2 or 4 with speed.
  function automatic int unsigned window_frames(input logic [1:0] code,
                                                input int unsigned base);
    int unsigned sh;
    sh = (code == 2'b00) ? 0 : ((code == 2'b01) ? 1 : 2);
    return base << sh;
  endfunction

  function automatic mode_e mode_of(input state_e s);
    case (s)
      ST_WAIT: return MODE_PEND;
      ST_HW:   return MODE_HW;
      default: return MODE_SW;
    endcase
  endfunction

  function automatic logic is_low_power(input state_e s);
    return (s == ST_WAIT) || (s == ST_HOLD);
  endfunction

  function automatic logic is_running(input state_e s);
    return (s == ST_HW) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/pwrseq_edge.sv
module pwrseq_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/pwrseq_window.sv
module pwrseq_window
  import pwrseq_pkg::*;
#(
  parameter int BASE_FRAMES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       frame_edge,
  input  logic [1:0] speed_code,
  output logic       expire
);
  localparam int MAX_FRAMES = BASE_FRAMES * 4;
  localparam int CW         = $clog2(MAX_FRAMES) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_w;
  logic          last_w;

  assign len_w  = CW'(window_frames(speed_code, BASE_FRAMES));
  assign last_w = (cnt_q >= len_w - CW'(1));
  assign expire = active & frame_edge & last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!active)              cnt_q <= '0;
    else if (frame_edge && !last_w) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int RAMP_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ramp_end
);
  localparam int RW = $clog2(RAMP_CYCLES + 1) + 1;

  logic [RW-1:0] cnt_q;

  assign ramp_end = run & (cnt_q == RW'(RAMP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!ramp_end) cnt_q <= cnt_q + RW'(1);
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrseq_pkg::*;
#(
  parameter int BASE_FRAMES = 512,
  parameter int RAMP_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic [1:0] speed_code,
  input  logic       cpen_wr,
  input  logic       pdn_bit,
  output logic [1:0] mode_sel,
  output logic       low_power,
  output logic       pwrup_done
);
  state_e state_q, state_d;

  // Named internal events, visible to the bound checker.
  logic frame_edge;
  logic win_active;
  logic win_expire;
  logic ramp_active;
  logic ramp_end;

  assign win_active  = (state_q == ST_WAIT);
  assign ramp_active = (state_q == ST_RAMP);

  pwrseq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (frame_clk),
    .rise     (frame_edge)
  );

  pwrseq_window #(.BASE_FRAMES(BASE_FRAMES)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (win_active),
    .frame_edge (frame_edge),
    .speed_code (speed_code),
    .expire     (win_expire)
  );

  pwrseq_ramp #(.RAMP_CYCLES(RAMP_CYCLES)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ramp_active),
    .ramp_end (ramp_end)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT: begin
        if (cpen_wr)         state_d = ST_HOLD;
        else if (win_expire) state_d = ST_HW;
      end
      ST_HW:   if (cpen_wr)  state_d = ST_HOLD;
      ST_HOLD: if (!pdn_bit) state_d = ST_RAMP;
      ST_RAMP: begin
        if (pdn_bit)       state_d = ST_HOLD;
        else if (ramp_end) state_d = ST_RUN;
      end
      ST_RUN:  if (pdn_bit)  state_d = ST_HOLD;
      default:               state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  assign mode_sel   = mode_of(state_q);
  assign low_power  = is_low_power(state_q);
  assign pwrup_done = is_running(state_q);
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpen_wr,
  input logic       pdn_bit,
  input logic [1:0] mode_sel,
  input logic       low_power,
  input logic       pwrup_done,
  input logic       frame_edge,
  input logic       win_expire,
  input logic       ramp_end
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode_sel == 2'b00 && low_power && !pwrup_done)); // R1

  AST_EXPIRE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |-> frame_edge); // R2

  AST_NO_EARLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !win_expire) |=> mode_sel != 2'b10); // R3

  AST_EXPIRE_TO_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && win_expire && !cpen_wr) |=>
      (mode_sel == 2'b10 && pwrup_done && !low_power)); // R3

  AST_EARLY_CPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && cpen_wr) |=> mode_sel == 2'b01); // R4

  AST_LATE_CPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && cpen_wr) |=>
      (mode_sel == 2'b01 && low_power && !pwrup_done)); // R5

  AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> mode_sel == 2'b01); // R6

  AST_HOLD_WHILE_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && pdn_bit) |=> (low_power && !pwrup_done)); // R7

  AST_DONE_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwrup_done) && mode_sel == 2'b01) |-> $past(ramp_end)); // R8

  AST_POWER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_power && pwrup_done)); // R7

  AST_PDN_REHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && !low_power && pdn_bit) |=> (low_power && !pwrup_done)); // R9
endmodule

bind pwrup_seq pwrseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpen_wr    (cpen_wr),
  .pdn_bit    (pdn_bit),
  .mode_sel   (mode_sel),
  .low_power  (low_power),
  .pwrup_done (pwrup_done),
  .frame_edge (frame_edge),
  .win_expire (win_expire),
  .ramp_end   (ramp_end)
);

// File: tb/sim_pwrup_seq.sv
`timescale 1ns/1ps
module sim_pwrup_seq;
  localparam int B  = 8;
  localparam int RC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic [1:0] speed_code = 2'b00;
  logic       cpen_wr = 1'b0;
  logic       pdn_bit = 1'b1;
  logic [1:0] mode_sel;
  logic       low_power;
  logic       pwrup_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwrup_seq #(.BASE_FRAMES(B), .RAMP_CYCLES(RC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .speed_code(speed_code),
    .cpen_wr(cpen_wr), .pdn_bit(pdn_bit), .mode_sel(mode_sel),
    .low_power(low_power), .pwrup_done(pwrup_done)
  );

  function automatic int exp_window(input logic [1:0] code);
    case (code)
      2'b00:   return B;
      2'b01:   return B * 2;
      default: return B * 4;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req, input int m, input int lp, input int dn);
    check({req, " mode"}, int'(mode_sel), m);
    check({req, " low_power"}, int'(low_power), lp);
    check({req, " done"}, int'(pwrup_done), dn);
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; frame_clk = 1'b0; cpen_wr = 1'b0; pdn_bit = 1'b1;
    speed_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = 1'b1;
      repeat (3) @(negedge clk);
      frame_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_cpen;
    cpen_wr = 1'b1;
    @(negedge clk);
    cpen_wr = 1'b0;
  endtask

  // Clears pdn and checks the ramp length; leaves pdn at 0.
  task automatic ramp_check(input string req);
    pdn_bit = 1'b0;
    @(negedge clk);
    check_state({req, " ramp start"}, 1, 0, 0);
    repeat (RC - 1) @(negedge clk);
    check({req, " done one short"}, int'(pwrup_done), 0);
    @(negedge clk);
    check({req, " done at end"}, int'(pwrup_done), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R1: reset defaults, during reset and right after release
    @(negedge clk);
    check_state("R1 in reset", 0, 1, 0);
    do_reset(2'b00);
    @(negedge clk);
    check_state("R1 after release", 0, 1, 0);

    // R2 / R3: each speed code, one frame short and then exact
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1:0]);
      frames(exp_window(c[1:0]) - 1);
      check_state($sformatf("R2 code %0d one short", c), 0, 1, 0);
      frames(1);
      check_state($sformatf("R3 code %0d expired", c), 2, 0, 1);
    end

    // R5: late enable after hardware mode
    pulse_cpen();
    check_state("R5 late cpen", 1, 1, 0);

    // R6: further writes and frames ignored
    pulse_cpen();
    frames(3);
    check_state("R6 sticky", 1, 1, 0);

    // R7: held while pdn is 1
    repeat (10) @(negedge clk);
    check_state("R7 hold", 1, 1, 0);

    // R8: ramp timing
    ramp_check("R8");

    // R9: pdn back to 1 after done, then mid-ramp, then full ramp again
    pdn_bit = 1'b1;
    @(negedge clk);
    check_state("R9 rehold after done", 1, 1, 0);
    pdn_bit = 1'b0;
    repeat (RC / 2) @(negedge clk);
    pdn_bit = 1'b1;
    @(negedge clk);
    check_state("R9 rehold mid ramp", 1, 1, 0);
    ramp_check("R9 restart");

    // R4: early enable inside the window
    do_reset(2'b01);
    frames(3);
    pulse_cpen();
    check_state("R4 early cpen", 1, 1, 0);
    frames(exp_window(2'b01));
    check_state("R6 frames after sw", 1, 1, 0);

    // Random runs
    for (int it = 0; it < 10; it++) begin
      logic [1:0] code;
      int w, k;
      code = 2'($urandom % 4);
      w = exp_window(code);
      k = int'($urandom % (w + 4));
      do_reset(code);
      if (k < w) begin
        frames(k);
        check_state("R4 rnd before cpen", 0, 1, 0);
        pulse_cpen();
        check_state("R4 rnd cpen", 1, 1, 0);
      end else begin
        frames(w);
        check_state("R3 rnd expire", 2, 0, 1);
        frames(k - w);
        check_state("R3 rnd extra frames", 2, 0, 1);
        pulse_cpen();
        check_state("R5 rnd late cpen", 1, 1, 0);
      end
      ramp_check("R8 rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule